// File: doc/BRIEF.md
# Crop Window with Fractional Downscaler

This block sits in a video capture path after the input unpacker. It takes one pixel per cycle, with an 8-bit luma and an 8-bit chroma byte and two markers: frame start and line start. It keeps only the pixels that fall inside a programmable rectangle. It then thins the surviving pixels on each axis by an independent N/M ratio, using nearest-sample decimation, and emits them with regenerated frame and line markers. The first pixel of each frame and line is re-marked, so a downstream writer can start a new line or buffer without counting.

Two optional stages refine the stream. The first is a binary luma mode: each luma byte is compared against a threshold to give a one-bit result, and chroma is discarded. The second applies to embedded-sync sources. There a control bit makes blanking pixels (luma 0x10, chroma 0x80) vanish before the crop counters see them. Configuration is expected to stay stable while a frame is in flight. Output appears one clock after the input pixel that produced it.

Top module: `crop_decimator`

## Requirements
- R1: While reset is asserted, and after it until the first kept pixel, out_valid, out_sof and out_sol are 0.
- R2: A pixel is kept horizontally only if its column index c (0 at the pixel flagged with in_sol) satisfies h_start <= c < h_start + h_size.
- R3: A pixel is kept vertically only if its row index r (0 at the line holding in_sof, +1 per in_sol) satisfies v_start <= r < v_start + v_size.
- R4: Inside the window, the k-th column (k = c - h_start, from 0) is kept when floor((k+1)*N/M) > floor(k*N/M), with the 16-bit N = cfg_h_num and M = cfg_h_den, so a window of width W yields floor(W*N/M) pixels per row.
- R5: The same rule, using cfg_v_num and cfg_v_den and the in-window row index, selects which rows are kept.
- R6: On an axis where N equals M, or N is 0, or M is 0, every in-window sample on that axis is kept.
- R7: out_sol is 1 on the first output pixel of each input line that produces output, and out_sof is 1 (together with out_sol) on the first output pixel of each frame.
- R8: With cfg_bin_en set, out_y is 8'h01 when luma >= cfg_bin_thr and 8'h00 otherwise, and out_c is 8'h00; with it clear, out_y and out_c carry the input bytes.
- R9: With cfg_embed and cfg_drop_blank both set, an input pixel with luma 8'h10 and chroma 8'h80 is treated as absent: it is not output and does not advance the column count.
- R10: With cfg_drop_blank clear or cfg_embed clear, blanking-valued pixels are ordinary pixels: they count as columns and are output when kept.
- R11: A kept pixel appears on the outputs exactly one cycle after it is presented; a cycle with in_valid low produces no output in the next cycle and advances no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame (implies line start) |
| in_sol | input | 1 | First pixel of a line |
| in_y | input | 8 | Input luma |
| in_c | input | 8 | Input chroma |
| cfg_h_start | input | 12 | First kept column |
| cfg_h_size | input | 12 | Crop width |
| cfg_v_start | input | 11 | First kept row |
| cfg_v_size | input | 11 | Crop height |
| cfg_h_num | input | 16 | Horizontal ratio numerator |
| cfg_h_den | input | 16 | Horizontal ratio denominator |
| cfg_v_num | input | 16 | Vertical ratio numerator |
| cfg_v_den | input | 16 | Vertical ratio denominator |
| cfg_bin_en | input | 1 | Binary luma output mode |
| cfg_bin_thr | input | 8 | Luma threshold for binary mode |
| cfg_embed | input | 1 | Source uses embedded sync |
| cfg_drop_blank | input | 1 | Suppress blanking pixels in embedded mode |
| out_valid | output | 1 | Output pixel present |
| out_sof | output | 1 | First output pixel of a frame |
| out_sol | output | 1 | First output pixel of a line |
| out_y | output | 8 | Output luma or binary luma |
| out_c | output | 8 | Output chroma (zero in binary mode) |

## Verification
The hardest case to reach is a blanking pixel dropped in the middle of a line while the horizontal accumulator sits partway through a fractional ratio. A wrong column advance there shifts every later decision in that row by one sample. The bench therefore inserts blanking pixels at random positions after the first column of each row, in frames with random non-unity ratios and random crop offsets, and mixes in random idle cycles. It also runs directed frames with blanking values as ordinary data when dropping is off, and threshold edges at 0 and 255.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int PIX_W = 8;
    localparam logic [PIX_W-1:0] BLANK_Y = 8'h10;
    localparam logic [PIX_W-1:0] BLANK_C = 8'h80;

    typedef struct packed {
        logic             valid;
        logic             sof;
        logic             sol;
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] c;
    } out_pix_t;
endpackage

// File: rtl/csd_frac_step.sv
// Nearest-sample accept unit for one axis: adds num per sample and
// accepts when the running sum reaches den, then removes den.
module csd_frac_step #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [AW-1:0] num,
    input  logic [AW-1:0] den,
    output logic          take
);
    typedef struct packed {
        logic [AW-1:0] acc;
    } acc_st_t;

    acc_st_t     st_d, st_q;
    logic [AW:0] base;
    logic [AW:0] sum;
    logic [AW:0] rem;
    logic        bypass;

    always_comb begin
        bypass = (num == den) || (num == '0) || (den == '0);
        base   = clear ? '0 : {1'b0, st_q.acc};
        sum    = base + {1'b0, num};
        take   = bypass || (sum >= {1'b0, den});
        rem    = (sum >= {1'b0, den}) ? sum - {1'b0, den} : sum;
        st_d   = st_q;
        if (step) begin
            st_d.acc = bypass ? '0 : rem[AW-1:0];
        end else if (clear) begin
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/csd_pos_track.sv
// Column and row position of the current pixel and window membership.
module csd_pos_track #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          px,
    input  logic          sol,
    input  logic          sof,
    input  logic [HW-1:0] h_start,
    input  logic [HW-1:0] h_size,
    input  logic [VW-1:0] v_start,
    input  logic [VW-1:0] v_size,
    output logic          h_in,
    output logic          v_in
);
    typedef struct packed {
        logic [HW-1:0] col;
        logic [VW-1:0] row;
    } pos_st_t;

    pos_st_t       st_d, st_q;
    logic [HW-1:0] cur_col;
    logic [VW-1:0] cur_row;
    logic [HW:0]   h_end;
    logic [VW:0]   v_end;

    always_comb begin
        cur_col = sol ? '0 : st_q.col;
        if (sof)      cur_row = '0;
        else if (sol) cur_row = st_q.row + 1'b1;
        else          cur_row = st_q.row;
        h_end = {1'b0, h_start} + {1'b0, h_size};
        v_end = {1'b0, v_start} + {1'b0, v_size};
        h_in  = (cur_col >= h_start) && ({1'b0, cur_col} < h_end);
        v_in  = (cur_row >= v_start) && ({1'b0, cur_row} < v_end);
        st_d  = st_q;
        if (px) begin
            st_d.col = cur_col + 1'b1;
            st_d.row = cur_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/crop_decimator.sv
module crop_decimator #(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    input  logic [7:0]    in_y,
    input  logic [7:0]    in_c,
    input  logic [HW-1:0] cfg_h_start,
    input  logic [HW-1:0] cfg_h_size,
    input  logic [VW-1:0] cfg_v_start,
    input  logic [VW-1:0] cfg_v_size,
    input  logic [SW-1:0] cfg_h_num,
    input  logic [SW-1:0] cfg_h_den,
    input  logic [SW-1:0] cfg_v_num,
    input  logic [SW-1:0] cfg_v_den,
    input  logic          cfg_bin_en,
    input  logic [7:0]    cfg_bin_thr,
    input  logic          cfg_embed,
    input  logic          cfg_drop_blank,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_sol,
    output logic [7:0]    out_y,
    output logic [7:0]    out_c
);
    import csd_pkg::*;

    localparam int N_AXES = 2;
    localparam int AX_H   = 0;
    localparam int AX_V   = 1;

    typedef struct packed {
        logic     row_keep;
        logic     need_sof;
        logic     need_sol;
        out_pix_t o;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          is_blank;
    logic          px;
    logic          sol_eff;
    logic          h_in, v_in;
    logic          nsof, nsol;
    logic          vkeep, keep;
    logic [SW-1:0] ax_num  [N_AXES];
    logic [SW-1:0] ax_den  [N_AXES];
    logic          ax_clr  [N_AXES];
    logic          ax_stp  [N_AXES];
    logic          ax_take [N_AXES];

    assign is_blank = cfg_embed && cfg_drop_blank &&
                      (in_y == BLANK_Y) && (in_c == BLANK_C);
    assign px       = in_valid && !is_blank;
    assign sol_eff  = in_sol || in_sof;

    csd_pos_track #(.HW(HW), .VW(VW)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .px      (px),
        .sol     (sol_eff),
        .sof     (in_sof),
        .h_start (cfg_h_start),
        .h_size  (cfg_h_size),
        .v_start (cfg_v_start),
        .v_size  (cfg_v_size),
        .h_in    (h_in),
        .v_in    (v_in)
    );

    assign ax_num[AX_H] = cfg_h_num;
    assign ax_den[AX_H] = cfg_h_den;
    assign ax_clr[AX_H] = px && sol_eff;
    assign ax_stp[AX_H] = px && h_in;
    assign ax_num[AX_V] = cfg_v_num;
    assign ax_den[AX_V] = cfg_v_den;
    assign ax_clr[AX_V] = px && in_sof;
    assign ax_stp[AX_V] = px && sol_eff && v_in;

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        csd_frac_step #(.AW(SW)) u_step (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (ax_clr[g]),
            .step  (ax_stp[g]),
            .num   (ax_num[g]),
            .den   (ax_den[g]),
            .take  (ax_take[g])
        );
    end

    always_comb begin
        vkeep = sol_eff ? (v_in && ax_take[AX_V]) : st_q.row_keep;
        keep  = px && h_in && v_in && vkeep && ax_take[AX_H];
        nsof  = in_sof || st_q.need_sof;
        nsol  = sol_eff || st_q.need_sol;

        st_d = st_q;
        if (px) begin
            if (sol_eff) st_d.row_keep = v_in && ax_take[AX_V];
            st_d.need_sof = nsof && !keep;
            st_d.need_sol = nsol && !keep;
        end
        st_d.o.valid = keep;
        st_d.o.sof   = keep && nsof;
        st_d.o.sol   = keep && nsol;
        if (keep) begin
            st_d.o.y = cfg_bin_en ? {7'd0, (in_y >= cfg_bin_thr)} : in_y;
            st_d.o.c = cfg_bin_en ? 8'd0 : in_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.o.valid;
    assign out_sof   = st_q.o.sof;
    assign out_sol   = st_q.o.sol;
    assign out_y     = st_q.o.y;
    assign out_c     = st_q.o.c;
endmodule

// File: rtl/crop_decimator_chk.sv
module crop_decimator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_y,
    input logic [7:0] in_c,
    input logic       cfg_bin_en,
    input logic [7:0] cfg_bin_thr,
    input logic       cfg_embed,
    input logic       cfg_drop_blank,
    input logic       out_valid,
    input logic       out_sof,
    input logic       out_sol,
    input logic [7:0] out_y,
    input logic [7:0] out_c
);
    a_r11_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r7_sof_with_sol: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_sol && out_valid));

    a_r7_sol_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    a_r8_binary_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_bin_en) |=> (!out_valid || (out_y[7:1] == 7'd0 && out_c == 8'd0)));

    a_r8_below_thr: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_bin_en && (in_y < cfg_bin_thr)) |=> (!out_valid || out_y == 8'd0));

    a_r9_blank_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_embed && cfg_drop_blank && in_y == 8'h10 && in_c == 8'h80)
        |=> !out_valid);
endmodule

bind crop_decimator crop_decimator_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_y           (in_y),
    .in_c           (in_c),
    .cfg_bin_en     (cfg_bin_en),
    .cfg_bin_thr    (cfg_bin_thr),
    .cfg_embed      (cfg_embed),
    .cfg_drop_blank (cfg_drop_blank),
    .out_valid      (out_valid),
    .out_sof        (out_sof),
    .out_sol        (out_sol),
    .out_y          (out_y),
    .out_c          (out_c)
);

// File: tb/crop_decimator_tb.sv
module crop_decimator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [7:0]  in_y = '0, in_c = '0;
    logic [11:0] cfg_h_start = '0, cfg_h_size = 12'd4095;
    logic [10:0] cfg_v_start = '0, cfg_v_size = 11'd2047;
    logic [15:0] cfg_h_num = 16'd1, cfg_h_den = 16'd1;
    logic [15:0] cfg_v_num = 16'd1, cfg_v_den = 16'd1;
    logic        cfg_bin_en = 1'b0;
    logic [7:0]  cfg_bin_thr = 8'd128;
    logic        cfg_embed = 1'b0, cfg_drop_blank = 1'b0;
    logic        out_valid, out_sof, out_sol;
    logic [7:0]  out_y, out_c;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    logic [17:0] exp_q[$];

    always #5 clk = ~clk;

    crop_decimator u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_y(in_y), .in_c(in_c),
        .cfg_h_start(cfg_h_start), .cfg_h_size(cfg_h_size),
        .cfg_v_start(cfg_v_start), .cfg_v_size(cfg_v_size),
        .cfg_h_num(cfg_h_num), .cfg_h_den(cfg_h_den),
        .cfg_v_num(cfg_v_num), .cfg_v_den(cfg_v_den),
        .cfg_bin_en(cfg_bin_en), .cfg_bin_thr(cfg_bin_thr),
        .cfg_embed(cfg_embed), .cfg_drop_blank(cfg_drop_blank),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_y(out_y), .out_c(out_c)
    );

    function automatic bit ax_take(longint k, longint n, longint m);
        if (n == m || n == 0 || m == 0) return 1'b1;
        return ((k + 1) * n) / m > (k * n) / m;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output monitor: compare each emitted pixel with the model queue.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            logic [17:0] act;
            act = {out_sof, out_sol, out_y, out_c};
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected output"}, act, 0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                check(act == e, {cur_tag, " pixel"}, act, e);
            end
        end
    end

    task automatic drive(logic v, logic f, logic l, logic [7:0] y, logic [7:0] c);
        @(negedge clk);
        in_valid = v; in_sof = f; in_sol = l; in_y = y; in_c = c;
    endtask

    // blank_mode: 0 none, 1 insert absent blanks, 2 blank values as data
    task automatic run_frame(int w, int h, int blank_mode, string tag);
        bit need_sof = 1'b1;
        cur_tag = tag;
        for (int r = 0; r < h; r++) begin
            bit need_sol = 1'b1;
            for (int c = 0; c < w; c++) begin
                logic [7:0] y, cc, ey, ec;
                bit hin, vin, keep;
                if ($urandom_range(0, 4) == 0) drive(0, 0, 0, 8'h00, 8'h00);
                if (blank_mode == 1 && c > 0 && $urandom_range(0, 3) == 0)
                    drive(1, 0, 0, 8'h10, 8'h80);
                y  = 8'($urandom);
                cc = 8'($urandom);
                if (blank_mode == 2 && $urandom_range(0, 2) == 0) begin
                    y = 8'h10; cc = 8'h80;
                end else if (y == 8'h10 && cc == 8'h80) begin
                    y = 8'h11;
                end
                hin  = (c >= cfg_h_start) && (c < int'(cfg_h_start) + int'(cfg_h_size));
                vin  = (r >= cfg_v_start) && (r < int'(cfg_v_start) + int'(cfg_v_size));
                keep = hin && vin &&
                       ax_take(c - cfg_h_start, cfg_h_num, cfg_h_den) &&
                       ax_take(r - cfg_v_start, cfg_v_num, cfg_v_den);
                if (keep) begin
                    ey = cfg_bin_en ? ((y >= cfg_bin_thr) ? 8'd1 : 8'd0) : y;
                    ec = cfg_bin_en ? 8'd0 : cc;
                    exp_q.push_back({need_sof, need_sol, ey, ec});
                    need_sof = 1'b0;
                    need_sol = 1'b0;
                end
                drive(1, (r == 0 && c == 0), (c == 0), y, cc);
            end
        end
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 8'h00, 8'h00);
        check(exp_q.size() == 0, {tag, " missing outputs"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic set_crop(int hs, int hw, int vs, int vh);
        cfg_h_start = 12'(hs); cfg_h_size = 12'(hw);
        cfg_v_start = 11'(vs); cfg_v_size = 11'(vh);
    endtask

    task automatic set_ratio(int hn, int hm, int vn, int vm);
        cfg_h_num = 16'(hn); cfg_h_den = 16'(hm);
        cfg_v_num = 16'(vn); cfg_v_den = 16'(vm);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!out_valid && !out_sof && !out_sol, "R1 during reset", out_valid, 0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!out_valid && !out_sof && !out_sol, "R1 after reset", out_valid, 0);
        end

        // R11: one-cycle latency of a single kept pixel
        cur_tag = "R11";
        set_crop(0, 4095, 0, 2047); set_ratio(1, 1, 1, 1);
        exp_q.push_back({1'b1, 1'b1, 8'hA5, 8'h3C});
        drive(1, 1, 1, 8'hA5, 8'h3C);
        drive(0, 0, 0, 8'h00, 8'h00);
        check(out_valid == 1'b1, "R11 latency one cycle", out_valid, 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R11 idle gives no output", out_valid, 0);

        // R6: bypass ratios
        set_ratio(5, 5, 0, 0);
        run_frame(10, 4, 0, "R6 R7");
        set_ratio(0, 9, 3, 0);
        run_frame(9, 5, 0, "R6");

        // R2, R3: crop only
        set_crop(3, 5, 2, 3); set_ratio(1, 1, 1, 1);
        run_frame(12, 7, 0, "R2 R3");
        set_crop(6, 40, 4, 20);
        run_frame(10, 6, 0, "R2 R3 clipped window");

        // R4: horizontal decimation
        set_crop(1, 13, 0, 2047); set_ratio(1, 2, 1, 1);
        run_frame(16, 3, 0, "R4 half");
        set_ratio(40000, 50000, 1, 1);
        run_frame(20, 2, 0, "R4 wide ratio");

        // R5: vertical decimation
        set_crop(0, 4095, 1, 9); set_ratio(1, 1, 2, 3);
        run_frame(6, 11, 0, "R5 R7");

        // R4, R5, R7: random crops and ratios
        for (int f = 0; f < 12; f++) begin
            int w, h, hm, vm;
            w = $urandom_range(4, 24); h = $urandom_range(2, 10);
            hm = $urandom_range(1, 7); vm = $urandom_range(1, 7);
            set_crop($urandom_range(0, w - 1), $urandom_range(1, w),
                     $urandom_range(0, h - 1), $urandom_range(1, h));
            set_ratio($urandom_range(1, hm), hm, $urandom_range(1, vm), vm);
            run_frame(w, h, 0, "R4 R5 R7 random");
        end

        // R8: binary luma
        set_crop(0, 4095, 0, 2047); set_ratio(2, 3, 1, 1);
        cfg_bin_en = 1'b1;
        cfg_bin_thr = 8'($urandom);
        run_frame(12, 4, 0, "R8 random threshold");
        cfg_bin_thr = 8'd0;
        run_frame(8, 2, 0, "R8 threshold 0");
        cfg_bin_thr = 8'd255;
        run_frame(8, 2, 0, "R8 threshold 255");
        cfg_bin_en = 1'b0;

        // R9: blanking dropped mid-line under fractional ratios
        cfg_embed = 1'b1; cfg_drop_blank = 1'b1;
        for (int f = 0; f < 6; f++) begin
            int hm;
            hm = $urandom_range(2, 6);
            set_crop($urandom_range(0, 3), $urandom_range(4, 16), 0, 2047);
            set_ratio($urandom_range(1, hm - 1), hm, 1, 1);
            run_frame(18, 4, 1, "R9 blank dropped");
        end

        // R10: blanking values are data when dropping is off
        set_crop(2, 10, 0, 2047); set_ratio(3, 4, 1, 1);
        cfg_drop_blank = 1'b0;
        run_frame(14, 4, 2, "R10 drop off");
        cfg_embed = 1'b0; cfg_drop_blank = 1'b1;
        run_frame(14, 4, 2, "R10 not embedded");
        cfg_drop_blank = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule